// File: doc/BRIEF.md
# Fixed Interval Timer with Period Select

This block produces a periodic event from a shared time-base tick enable. It counts enabled ticks, and when the selected interval has elapsed it raises a one-cycle event strobe. The strobe sets a sticky status flag. The timer then re-arms by itself with whatever period is selected at that moment. A 2-bit field of the control register value picks one of four power-of-two intervals. A separate control bit gates whether the sticky flag drives the interrupt output.

The status image is six bits wide and sits in the upper end of a 32-bit word. Software can load it by a write, which keeps only the six upper bits. Software can also drop the event flag with a clear strobe. An event always wins over a clear or a write in the same cycle, so no elapsed period is lost.

Top module: `fit_timer`

## Requirements
- R1: Reset clears the status word and the interrupt and restarts the count. The first period after reset uses the select value present in the first cycle out of reset.
- R2: Control bits 25:24 select the period. With the default parameters, 00 gives 2^9 enabled ticks, 01 gives 2^13, 10 gives 2^17 and 11 gives 2^21. In general the exponent is BASE_LOG2 + sel*STEP_LOG2.
- R3: On the enabled tick that completes a period, evt_o is high for exactly that cycle, and status bit 26 reads 1 from the next clock edge.
- R4: After each event the timer re-arms with no external action, so consecutive events are one full period apart.
- R5: A change of the select field does not shorten or lengthen the period in progress. It applies from the next re-arm.
- R6: Once set, status bit 26 stays 1 through further events until a clear strobe, or a status write with bit 26 at 0, removes it.
- R7: irq_o is 1 exactly when status bit 26 is 1 and control bit 23 is 1.
- R8: A status write stores write-data bits 31:26. stat_o bits 25:0 always read 0.
- R9: Cycles with tick_en low do not advance the count, and evt_o is never high without tick_en.
- R10: When an event coincides with a clear strobe or a status write, status bit 26 ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Time-base tick enable; one count per high cycle |
| ctrl_i | input | 32 | Timer control register value (bits 25:24 period select, bit 23 interrupt enable) |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 32 | Status write data; only bits 31:26 are kept |
| stat_clr | input | 1 | Clears status bit 26 |
| evt_o | output | 1 | Status set strobe, one cycle per elapsed period |
| stat_o | output | 32 | Status register value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the timer with BASE_LOG2 = 2 and STEP_LOG2 = 1, so the four selectable periods are 4, 8, 16 and 32 ticks. With these values every select code, several back-to-back re-arms, a select change in the middle of a period, and event-versus-clear collisions all fit in a few hundred cycles. The same decode and re-arm logic handles the default intervals of up to two million ticks.

// File: rtl/fit_pkg.sv
// fit_pkg: field positions and shared types of the fixed interval timer.
// Assumes a 32-bit control and status register layout.
package fit_pkg;
    localparam int REG_W         = 32;
    localparam int SEL_LSB       = 24;  // period select field, two bits
    localparam int IEN_BIT       = 23;  // interrupt enable
    localparam int STAT_KEEP_LSB = 26;  // lowest status bit that is stored
    localparam int STAT_EVT_BIT  = 26;  // event flag in the status word
    localparam int NUM_SEL       = 4;

    typedef logic [1:0] prd_sel_t;
endpackage

// File: rtl/fit_period_lut.sv
// fit_period_lut: turns the 2-bit select into the terminal count (period - 1).
// Assumes BASE_LOG2 + 3*STEP_LOG2 <= CNT_W and <= 63.
module fit_period_lut #(
    parameter int BASE_LOG2 = 9,
    parameter int STEP_LOG2 = 4,
    parameter int CNT_W     = BASE_LOG2 + 3 * STEP_LOG2
) (
    input  fit_pkg::prd_sel_t  sel_i,
    output logic [CNT_W-1:0]   term_o
);
    logic [CNT_W-1:0] term_tab [fit_pkg::NUM_SEL];

    // one terminal count for each select code
    for (genvar g = 0; g < fit_pkg::NUM_SEL; g++) begin : g_term
        localparam int      EXP  = BASE_LOG2 + g * STEP_LOG2;
        localparam longint  FULL = (64'sd1 <<< EXP) - 64'sd1;
        assign term_tab[g] = FULL[CNT_W-1:0];
    end

    // pick the entry named by the select field
    always_comb term_o = term_tab[sel_i];
endmodule

// File: rtl/fit_tick_counter.sv
// fit_tick_counter: counts enabled ticks against an armed terminal count.
// It pulses expire_o on the completing tick and re-arms from term_i at that moment.
// Assumes term_i is stable enough to sample once per period.
module fit_tick_counter #(
    parameter int CNT_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] term_i,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] term_q;
    logic             armed_q;
    logic [CNT_W-1:0] eff_term;

    // until armed after reset, the live select defines the first period
    always_comb eff_term = armed_q ? term_q : term_i;

    // expiry happens only on an enabled tick at the terminal count
    always_comb expire_o = tick_en && (cnt_q == eff_term);

    // count ticks, latch the period at arm time, restart on expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            term_q  <= '0;
            armed_q <= 1'b0;
        end else begin
            if (!armed_q) begin
                armed_q <= 1'b1;
                term_q  <= term_i;
            end
            if (tick_en) begin
                if (expire_o) begin
                    cnt_q  <= '0;
                    term_q <= term_i;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fit_status.sv
// fit_status: holds the stored upper status bits and the sticky event flag.
// Priority: write loads, then clear drops the flag, then an event sets it.
module fit_status #(
    parameter int KEEP_W  = 6,
    parameter int EVT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic              wr_i,
    input  logic [KEEP_W-1:0] wdata_i,
    input  logic              ien_i,
    output logic [KEEP_W-1:0] stat_o,
    output logic              irq_o
);
    logic [KEEP_W-1:0] stat_q;
    logic [KEEP_W-1:0] stat_nxt;

    // resolve write, clear and event into the next status image
    always_comb begin
        stat_nxt = wr_i ? wdata_i : stat_q;
        if (clr_i) stat_nxt[EVT_IDX] = 1'b0;
        if (set_i) stat_nxt[EVT_IDX] = 1'b1;
    end

    // status storage
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_nxt;
    end

    // the interrupt is the flag gated by the enable
    always_comb irq_o = stat_q[EVT_IDX] & ien_i;

    assign stat_o = stat_q;
endmodule

// File: rtl/fit_timer.sv
// fit_timer: fixed interval timer with a four-way power-of-two period select.
// It consumes the control value, drives the status set strobe, and keeps the
// status image. Assumes tick_en is synchronous to clk.
module fit_timer #(
    parameter int BASE_LOG2 = 9,
    parameter int STEP_LOG2 = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_en,
    input  logic [31:0] ctrl_i,
    input  logic        stat_wr,
    input  logic [31:0] stat_wdata,
    input  logic        stat_clr,
    output logic        evt_o,
    output logic [31:0] stat_o,
    output logic        irq_o
);
    import fit_pkg::*;

    localparam int CNT_W  = BASE_LOG2 + 3 * STEP_LOG2;
    localparam int KEEP_W = REG_W - STAT_KEEP_LSB;

    prd_sel_t          sel;
    logic [CNT_W-1:0]  term;
    logic [KEEP_W-1:0] keep;

    // decode the period select field
    always_comb sel = ctrl_i[SEL_LSB +: 2];

    fit_period_lut #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .CNT_W     (CNT_W)
    ) u_lut (
        .sel_i  (sel),
        .term_o (term)
    );

    fit_tick_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .term_i   (term),
        .expire_o (evt_o)
    );

    fit_status #(
        .KEEP_W  (KEEP_W),
        .EVT_IDX (STAT_EVT_BIT - STAT_KEEP_LSB)
    ) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_o),
        .clr_i   (stat_clr),
        .wr_i    (stat_wr),
        .wdata_i (stat_wdata[REG_W-1:STAT_KEEP_LSB]),
        .ien_i   (ctrl_i[IEN_BIT]),
        .stat_o  (keep),
        .irq_o   (irq_o)
    );

    // place the stored bits at the top of the status word
    assign stat_o = {keep, {STAT_KEEP_LSB{1'b0}}};
endmodule

// File: rtl/fit_timer_chk.sv
// fit_timer_chk: port-level properties of fit_timer, bound to every instance.
module fit_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_en,
    input logic [31:0] ctrl_i,
    input logic        stat_wr,
    input logic        stat_clr,
    input logic        evt_o,
    input logic [31:0] stat_o,
    input logic        irq_o
);
    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n) evt_o |=> stat_o[26]); // R3
    AST_FLAG_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) (stat_o[26] && !stat_clr && !stat_wr) |=> stat_o[26]); // R6
    AST_CLR_DROPS:     assert property (@(posedge clk) disable iff (!rst_n) (stat_clr && !stat_wr && !evt_o) |=> !stat_o[26]); // R6
    AST_IRQ_GATED:     assert property (@(posedge clk) disable iff (!rst_n) irq_o |-> (ctrl_i[23] && stat_o[26])); // R7
    AST_LOW_ZERO:      assert property (@(posedge clk) disable iff (!rst_n) stat_o[25:0] == 26'd0); // R8
    AST_EVT_ON_TICK:   assert property (@(posedge clk) disable iff (!rst_n) evt_o |-> tick_en); // R9
    AST_SET_WINS:      assert property (@(posedge clk) disable iff (!rst_n) (evt_o && (stat_clr || stat_wr)) |=> stat_o[26]); // R10
endmodule

bind fit_timer fit_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .ctrl_i   (ctrl_i),
    .stat_wr  (stat_wr),
    .stat_clr (stat_clr),
    .evt_o    (evt_o),
    .stat_o   (stat_o),
    .irq_o    (irq_o)
);

// File: tb/fit_timer_bench.sv
// fit_timer_bench: directed scenarios for fit_timer, built with periods 4/8/16/32.
module fit_timer_bench;
    localparam int BASE = 2;
    localparam int STEP = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [31:0] ctrl_i = 32'd0;
    logic        stat_wr = 1'b0;
    logic [31:0] stat_wdata = 32'd0;
    logic        stat_clr = 1'b0;
    logic        evt_o;
    logic [31:0] stat_o;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fit_timer #(.BASE_LOG2(BASE), .STEP_LOG2(STEP)) u_fit_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .ctrl_i(ctrl_i),
        .stat_wr(stat_wr), .stat_wdata(stat_wdata), .stat_clr(stat_clr),
        .evt_o(evt_o), .stat_o(stat_o), .irq_o(irq_o)
    );

    function automatic int period_of(input int sel);
        return 1 << (BASE + sel * STEP);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // control value: select, enable, plus noise in unrelated bits
    task automatic set_ctrl(input int sel, input bit ien);
        @(negedge clk);
        ctrl_i = 32'hC000_00A5 | (32'(sel) << 24) | (32'(ien) << 23);
    endtask

    task automatic tick_once(output bit ev);
        @(negedge clk);
        tick_en = 1'b1;
        #1 ev = evt_o;
        @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    task automatic ticks_to_event(output int n);
        bit ev;
        n = 0;
        do begin
            tick_once(ev);
            n++;
        end while (!ev && n < 200);
    endtask

    task automatic pulse_clr;
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
    endtask

    task automatic write_stat(input logic [31:0] v);
        @(negedge clk); stat_wr = 1'b1; stat_wdata = v;
        @(negedge clk); stat_wr = 1'b0;
    endtask

    task automatic t_reset;
        int n;
        ctrl_i = 32'h0200_0000;  // select 10 before release
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 status after reset", stat_o, 0);
        check("R1 irq after reset", irq_o, 0);
        check("R1 evt after reset", evt_o, 0);
        ticks_to_event(n);
        check("R1 first period uses select at release", n, period_of(2));
    endtask

    task automatic t_periods;
        int n;
        for (int s = 0; s < 4; s++) begin
            set_ctrl(s, 1'b0);
            ticks_to_event(n);          // finishes the period armed earlier
            ticks_to_event(n);
            check("R2 period for select", n, period_of(s));
            ticks_to_event(n);
            check("R4 re-armed period", n, period_of(s));
        end
    endtask

    task automatic t_deferred;
        int n;
        bit ev;
        set_ctrl(0, 1'b0);
        ticks_to_event(n);
        ticks_to_event(n);              // now aligned to a select-0 event
        tick_once(ev);
        set_ctrl(1, 1'b0);
        ticks_to_event(n);
        check("R5 old period completes", n, period_of(0) - 1);
        ticks_to_event(n);
        check("R5 new period after re-arm", n, period_of(1));
    endtask

    task automatic t_gate;
        int n;
        bit seen = 1'b0;
        set_ctrl(0, 1'b0);
        ticks_to_event(n);
        ticks_to_event(n);
        pulse_clr();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (evt_o) seen = 1'b1;
        end
        check("R9 no event without ticks", seen, 0);
        check("R9 flag untouched while idle", stat_o[26], 0);
        ticks_to_event(n);
        check("R9 count resumes unchanged", n, period_of(0));
    endtask

    task automatic t_sticky_irq;
        int n;
        set_ctrl(0, 1'b0);
        pulse_clr();
        ticks_to_event(n);
        #1;
        check("R3 flag set after event", stat_o[26], 1);
        check("R3 strobe lasts one cycle", evt_o, 0);
        check("R7 irq masked by enable", irq_o, 0);
        ticks_to_event(n);
        #1;
        check("R6 flag held over second event", stat_o[26], 1);
        set_ctrl(0, 1'b1);
        #1;
        check("R7 irq with flag and enable", irq_o, 1);
        pulse_clr();
        #1;
        check("R6 clear drops flag", stat_o[26], 0);
        check("R7 irq follows flag", irq_o, 0);
    endtask

    task automatic t_write;
        write_stat(32'hFFFF_FFFF);
        #1;
        check("R8 write keeps bits 31:26 only", stat_o, 32'hFC00_0000);
        check("R7 irq from written flag", irq_o, 1);
        write_stat(32'h03FF_FFFF);
        #1;
        check("R8 write of low bits reads zero", stat_o, 0);
        check("R6 write with bit 26 low drops flag", irq_o, 0);
    endtask

    task automatic t_setwins;
        int n;
        bit ev;
        set_ctrl(0, 1'b0);
        ticks_to_event(n);
        ticks_to_event(n);
        pulse_clr();
        for (int i = 0; i < period_of(0) - 1; i++) tick_once(ev);
        @(negedge clk);
        tick_en = 1'b1; stat_clr = 1'b1; stat_wr = 1'b1; stat_wdata = 32'h0;
        #1 ev = evt_o;
        @(posedge clk);
        #1 tick_en = 1'b0; stat_clr = 1'b0; stat_wr = 1'b0;
        check("R10 event on colliding tick", ev, 1);
        check("R10 event beats clear and write", stat_o, 32'h0400_0000);
    endtask

    initial begin
        t_reset();
        t_periods();
        t_deferred();
        t_gate();
        t_sticky_irq();
        t_write();
        t_setwins();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule